// File: doc/BRIEF.md
# Three-Digit Sequential Combination Lock

This block guards a door with a fixed three-digit code. Digits of `DIGIT_W` bits arrive one at a time on a valid/ready input. The lock compares each accepted digit against the stored digit for the current position. A matching digit moves the lock to the next position. A mismatch sends it to a locked-out error state. When the third matching digit is accepted, the door opens. Only a synchronous reset leaves the open state or the error state.

The datapath has a one-hot 3:1 selector over the three stored digits and a single shared equality comparator. The controller keeps its state in four flip-flops, and these flops are also the outputs. The top bit is the door-open flag and the low three bits are the one-hot selector control. The error state is all zeros, so it selects no digit.

Back-pressure rules are as follows. `digit_ready` is high only while the lock is waiting for the first, second or third digit. A digit is accepted on a rising edge where both `digit_valid` and `digit_ready` are high. A digit offered while `digit_ready` is low is dropped and has no effect. The source does not need to hold the digit after an accepting edge.

Top module: `combo_lock`

## Requirements
- R1: On a rising edge with `rst` high, the lock enters the first-digit state. After that edge `door_open`=0, `code_sel`=3'b001 and `digit_ready`=1, whatever state it was in before.
- R2: `code_sel` is always one-hot or zero. It is 3'b001, 3'b010 or 3'b100 while waiting for digit one, two or three, and 3'b000 when open or in error.
- R3: While waiting for a digit, an edge with `digit_valid` low leaves all outputs unchanged.
- R4: A digit that equals the stored digit for the current position moves the lock one position forward, visible one cycle after the accepting edge.
- R5: An accepted digit that differs from the stored digit for the current position puts the lock in the error state: `door_open`=0, `code_sel`=0, `digit_ready`=0.
- R6: After the third matching digit is accepted, `door_open` is 1 from the next cycle onward.
- R7: In the open state, offered digits and idle cycles have no effect, and `door_open` stays 1 until reset.
- R8: In the error state, offered digits, including correct ones, have no effect until reset.
- R9: When `rst` and `digit_valid` are high on the same edge, reset wins and the digit is discarded.
- R10: `digit_ready` is high exactly in the three digit-waiting states.
- R11: Each digit is compared only with the stored digit selected for its position. A digit that matches a different position's stored digit counts as wrong.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| digit_data | input | DIGIT_W | Entered digit |
| digit_valid | input | 1 | Digit present on `digit_data` |
| digit_ready | output | 1 | Lock will accept a digit this cycle |
| door_open | output | 1 | 1 = door open, 0 = closed |
| code_sel | output | 3 | One-hot selector of the stored digit now compared |

## Verification
The outputs are the state flops themselves, so any wrong state shows at `code_sel`, `door_open` and `digit_ready` in the cycle right after the edge that caused it. No decode logic can hide it. A bad comparator or selector shows up as an early error state, or as a missed error, one cycle after the digit concerned. The sweep offers every digit value at each of the three positions, so both kinds of fault are exposed. A leaky absorbing state shows up as a changed output after the next offered digit.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef logic [3:0] lock_state_t;
  // bit 3 = door open, bits 2:0 = one-hot stored-digit select
  localparam lock_state_t ST_D1   = 4'b0001;
  localparam lock_state_t ST_D2   = 4'b0010;
  localparam lock_state_t ST_D3   = 4'b0100;
  localparam lock_state_t ST_OPEN = 4'b1000;
  localparam lock_state_t ST_ERR  = 4'b0000;
  localparam int SEL_W = 3;
endpackage

// File: rtl/lock_code_mux.sv
module lock_code_mux #(
  parameter int W = 4
) (
  input  logic [2:0]   sel,
  input  logic [W-1:0] code_a,
  input  logic [W-1:0] code_b,
  input  logic [W-1:0] code_c,
  output logic [W-1:0] code_out
);
  // AND-OR selector per bit; all-zero select yields zero
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign code_out[i] = (sel[0] & code_a[i]) | (sel[1] & code_b[i]) | (sel[2] & code_c[i]);
  end
endmodule

// File: rtl/lock_digit_cmp.sv
module lock_digit_cmp #(
  parameter int W = 4
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic         same
);
  logic [W-1:0] bit_match;
  for (genvar i = 0; i < W; i++) begin : g_xnor
    assign bit_match[i] = ~(lhs[i] ^ rhs[i]);
  end
  assign same = &bit_match;
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        take,
  input  logic        match,
  output lock_state_t state
);
  logic        waiting;
  lock_state_t nxt;

  assign waiting = |state[2:0];

  always_comb begin
    nxt = state;
    if (waiting && take) begin
      // one-hot shift walks D1 -> D2 -> D3 -> OPEN
      nxt = match ? lock_state_t'(state << 1) : ST_ERR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_D1;
    else     state <= nxt;
  end

  p_reset_first_r1: assert property (@(posedge clk) rst |=> state == ST_D1);
  p_legal_sel_r2: assert property (@(posedge clk) disable iff (rst) $onehot0(state));
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst) !take |=> $stable(state));
  p_advance_r4: assert property (@(posedge clk) disable iff (rst)
    (waiting && take && match) |=> state == lock_state_t'($past(state) << 1));
  p_wrong_err_r5: assert property (@(posedge clk) disable iff (rst)
    (waiting && take && !match) |=> state == ST_ERR);
  p_open_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    state == ST_OPEN |=> state == ST_OPEN);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    state == ST_ERR |=> state == ST_ERR);
endmodule

// File: rtl/combo_lock.sv
module combo_lock
  import lock_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter logic [DIGIT_W-1:0] CODE_FIRST  = 4'h3,
  parameter logic [DIGIT_W-1:0] CODE_SECOND = 4'h9,
  parameter logic [DIGIT_W-1:0] CODE_THIRD  = 4'hC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIGIT_W-1:0] digit_data,
  input  logic               digit_valid,
  output logic               digit_ready,
  output logic               door_open,
  output logic [SEL_W-1:0]   code_sel
);
  lock_state_t        st;
  logic [DIGIT_W-1:0] picked;
  logic               eq;

  lock_code_mux #(.W(DIGIT_W)) u_mux (
    .sel(st[2:0]), .code_a(CODE_FIRST), .code_b(CODE_SECOND),
    .code_c(CODE_THIRD), .code_out(picked)
  );

  lock_digit_cmp #(.W(DIGIT_W)) u_cmp (
    .lhs(digit_data), .rhs(picked), .same(eq)
  );

  lock_ctrl u_ctrl (
    .clk(clk), .rst(rst), .take(digit_valid & digit_ready),
    .match(eq), .state(st)
  );

  assign code_sel    = st[2:0];
  assign door_open   = st[3];
  assign digit_ready = |st[2:0];

  p_ready_match_r10: assert property (@(posedge clk) disable iff (rst)
    digit_ready |-> !door_open);
  p_open_after_third_r6: assert property (@(posedge clk) disable iff (rst)
    (code_sel == 3'b100 && digit_valid && digit_data == CODE_THIRD) |=> door_open);
endmodule

// File: tb/tb_combo_lock.sv
module tb_combo_lock;
  localparam logic [3:0] K0 = 4'h3, K1 = 4'h9, K2 = 4'hC;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] digit_data = '0;
  logic       digit_valid = 1'b0;
  logic       digit_ready, door_open;
  logic [2:0] code_sel;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  combo_lock #(.DIGIT_W(4), .CODE_FIRST(K0), .CODE_SECOND(K1), .CODE_THIRD(K2)) dut (
    .clk(clk), .rst(rst), .digit_data(digit_data), .digit_valid(digit_valid),
    .digit_ready(digit_ready), .door_open(door_open), .code_sel(code_sel)
  );

  function automatic logic [3:0] key(int k);
    return (k == 0) ? K0 : (k == 1) ? K1 : K2;
  endfunction

  // drive at a falling edge, let one rising edge pass, return at next falling edge
  task automatic cyc(logic r, logic v, logic [3:0] d);
    rst = r; digit_valid = v; digit_data = d;
    @(negedge clk);
    rst = 1'b0; digit_valid = 1'b0;
  endtask

  // pos: 0..2 waiting for digit pos+1, 3 open, 4 error
  task automatic expect_pos(int pos, string tag);
    logic [4:0] exp_v, act_v;
    exp_v = {pos == 3, (pos < 3) ? 3'(1 << pos) : 3'b000, pos < 3};
    act_v = {door_open, code_sel, digit_ready};
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: {open,sel,ready} actual=%b expected=%b", tag, act_v, exp_v);
    end
  endtask

  initial begin
    @(negedge clk);
    cyc(1'b1, 1'b0, 4'h0);
    expect_pos(0, "R1 reset state");

    // sweep every value at every position (R4 R5 R6 R11 R2 R10)
    for (int k = 0; k < 3; k++) begin
      for (int v = 0; v < 16; v++) begin
        int exp_pos;
        cyc(1'b1, 1'b0, 4'h0);
        for (int j = 0; j < k; j++) begin
          cyc(1'b0, 1'b1, key(j));
          expect_pos(j + 1, "R4 advance");
        end
        cyc(1'b0, 1'b1, 4'(v));
        exp_pos = (4'(v) == key(k)) ? k + 1 : 4;
        expect_pos(exp_pos, (exp_pos == 4) ? "R5/R11 wrong digit" :
                            (exp_pos == 3) ? "R6 opened" : "R4 advance");
        // offered digits after the outcome (R7 R8 R10 when absorbing)
        cyc(1'b0, 1'b1, key(0));
        if (exp_pos >= 3) expect_pos(exp_pos, (exp_pos == 3) ? "R7 open sticky" : "R8 err sticky");
        cyc(1'b0, 1'b1, 4'(v));
        cyc(1'b0, 1'b0, 4'h0);
        if (exp_pos >= 3) expect_pos(exp_pos, (exp_pos == 3) ? "R7 open sticky" : "R8 err sticky");
      end
    end

    // idle gaps between digits (R3)
    cyc(1'b1, 1'b0, 4'h0);
    for (int j = 0; j < 3; j++) begin
      for (int g = 0; g < 3; g++) begin
        cyc(1'b0, 1'b0, ~key(j));
        expect_pos(j, "R3 idle hold");
      end
      cyc(1'b0, 1'b1, key(j));
      expect_pos(j + 1, "R4 advance after idle");
    end

    // reset from open (R1)
    cyc(1'b1, 1'b0, 4'h0);
    expect_pos(0, "R1 reset from open");

    // reset wins over valid mid-sequence (R9)
    cyc(1'b0, 1'b1, K0);
    cyc(1'b0, 1'b1, K1);
    expect_pos(2, "R4 advance");
    cyc(1'b1, 1'b1, K2);
    expect_pos(0, "R9 reset priority");
    cyc(1'b1, 1'b1, K0);
    expect_pos(0, "R9 reset priority with first digit");
    for (int j = 0; j < 3; j++) cyc(1'b0, 1'b1, key(j));
    expect_pos(3, "R6 open after reset");

    // reset from error (R1)
    cyc(1'b1, 1'b0, 4'h0);
    cyc(1'b0, 1'b1, K1);
    expect_pos(4, "R11 second digit in first slot");
    cyc(1'b1, 1'b0, 4'h0);
    expect_pos(0, "R1 reset from error");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule